// File: doc/BRIEF.md
# Rotated Immediate Encoding Finder

This block decides whether a 32-bit constant fits a compact immediate form. In that form an 8-bit field is rotated right inside the word by an even number of bit positions, so a 4-bit rotate field `r` selects a rotation of `2*r`. When the constant fits, the block returns the 8-bit field and the smallest rotate field that rebuilds it. When it does not fit, the block finds the nearest value that does fit. A direction input chooses whether that value lies at or below the constant, or at or above it.

A start pulse latches the constant and the direction. The block then tries one rotation per clock, for all sixteen even rotations in rising order. This includes rotations whose 8-bit window wraps from bit 31 around to bit 0. For each rotation it forms the best candidate on the requested side and keeps the closest candidate seen so far. A one-cycle done pulse marks the end of the search. The results stay on the outputs until the next search completes.

The block is meant for a code generator or a constant-materialisation helper. That caller needs either the encoded field or a near neighbour that fits, so that it can cover the remainder with a small correction.

Top module: `rimm_finder`

## Requirements
- R1: `exact_o` is 1 after a search exactly when the latched constant equals `ror(k, 2r)` for some 8-bit `k` and some `r` in 0..15. In that case `result_o` equals the constant. For example, 0x00005000 gives `exact_o`=1 and 0x00005001 gives `exact_o`=0.
- R2: When `valid_o` is 1, `result_o` equals `imm_o` zero-extended to 32 bits and rotated right by `2*rot_o`. `rot_o` is the smallest rotate field that yields `result_o`.
- R3: With `up_i`=0, `result_o` is the largest encodable value not greater than the constant. For example, 0x00005001 gives 0x00005000.
- R4: With `up_i`=1, `result_o` is the smallest encodable value not less than the constant.
- R5: Constants whose set bits wrap across bit 31 and bit 0 are handled under every rotation. For example, 0x80000001 is encodable with `imm_o`=0x06 and `rot_o`=1.
- R6: A constant of zero gives `valid_o`=1, `exact_o`=1, `result_o`=0, `imm_o`=0 and `rot_o`=0, in either direction.
- R7: With `up_i`=1 and a constant above 0xFF000000, there is no candidate. In that case `valid_o`=0 and `result_o`, `imm_o` and `rot_o` are all 0.
- R8: `done_o` goes high for exactly one cycle, 16 clock edges after the edge that samples `start_i`.
- R9: `start_i`, `value_i` and `up_i` are ignored while a search is in progress. The results reflect only the accepted constant.
- R10: After reset, `done_o`, `valid_o`, `exact_o`, `result_o`, `imm_o` and `rot_o` are all 0. The results hold their values after `done_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a search when idle |
| value_i | input | 32 | Constant to encode |
| up_i | input | 1 | 1 searches at or above the constant, 0 at or below it |
| done_o | output | 1 | One-cycle pulse when the results are updated |
| valid_o | output | 1 | A result exists on the requested side |
| exact_o | output | 1 | The constant itself is encodable |
| result_o | output | 32 | Chosen encodable value |
| imm_o | output | 8 | 8-bit field of the result |
| rot_o | output | 4 | Rotate field; rotation is twice this value, to the right |

## Verification
All results appear on the clock edge 16 edges after the edge that samples `start_i`, together with `done_o`. The bench drives inputs on falling edges and samples on falling edges. It checks that `done_o` is low at each of the first 15 falling edges and high at the 16th. It compares all result outputs at that 16th falling edge, and again one edge later when `done_o` has fallen and the values must have held. Expected values come from an exhaustive search in the bench over all 4096 rotated 8-bit values. Random and sparse constants are mixed with directed corner cases, and a start pulse with a different constant is injected mid-search.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
  localparam int unsigned DEF_WORD_W = 32;
  localparam int unsigned DEF_IMM_W  = 8;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } dir_e;
endpackage

// File: rtl/rimm_step.sv
// Evaluates one even rotation: exact hit, or best candidate on one side.
module rimm_step #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic [W-1:0]     value_i,
  input  logic [ROT_W-1:0] rot_i,
  input  rimm_pkg::dir_e   dir_i,
  output logic             exact_o,
  output logic [IMM_W-1:0] exact_imm_o,
  output logic             cand_ok_o,
  output logic [W-1:0]     cand_o,
  output logic [IMM_W-1:0] cand_imm_o
);
  localparam logic [W:0] IMM_MAX = (W+1)'((1 << IMM_W) - 1);

  logic [2*W-1:0] dbl_v, dbl_c;
  logic [W-1:0]   win;
  logic [W:0]     q, qc;
  logic [W-1:0]   t, top_max;
  logic           rem_nz;
  int             sh, p, lo_bits;

  always_comb begin
    sh        = 2 * int'(rot_i);
    p         = (sh == 0) ? 0 : int'(W) - sh;
    lo_bits   = 0;
    dbl_v     = {value_i, value_i};
    // window = value rotated left by sh
    win       = dbl_v[(2*W-1-sh) -: W];
    exact_o   = (win[W-1:IMM_W] == '0);
    exact_imm_o = win[IMM_W-1:0];
    cand_ok_o = 1'b0;
    cand_o    = '0;
    q         = '0;
    qc        = '0;
    t         = '0;
    top_max   = '0;
    rem_nz    = 1'b0;
    if (!exact_o) begin
      if (p <= int'(W - IMM_W)) begin
        q      = {1'b0, value_i >> p};
        rem_nz = |(value_i & ~({W{1'b1}} << p));
        if (dir_i == rimm_pkg::DIR_DOWN) begin
          cand_ok_o = 1'b1;
          qc        = (q > IMM_MAX) ? IMM_MAX : q;
        end else begin
          qc        = q + {{W{1'b0}}, rem_nz};
          cand_ok_o = (qc <= IMM_MAX);
        end
        cand_o = qc[W-1:0] << p;
      end else begin
        // window wraps: top (W-p) bits and bottom lo_bits bits
        lo_bits = int'(IMM_W) - (int'(W) - p);
        t       = value_i >> p;
        top_max = ~({W{1'b1}} << (int'(W) - p));
        if (dir_i == rimm_pkg::DIR_DOWN) begin
          cand_ok_o = 1'b1;
          cand_o    = (t << p) | ~({W{1'b1}} << lo_bits);
        end else begin
          cand_ok_o = (t != top_max);
          cand_o    = (t + 1'b1) << p;
        end
      end
      if (!cand_ok_o) cand_o = '0;
    end
    dbl_c      = {cand_o, cand_o};
    cand_imm_o = dbl_c[(int'(W)-sh+int'(IMM_W)-1) -: IMM_W];
  end
endmodule

// File: rtl/rimm_ctrl.sv
module rimm_ctrl #(
  parameter int unsigned STEPS = 16,
  parameter int unsigned ROT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic [ROT_W-1:0] step_o,
  output logic             done_o
);
  localparam logic [ROT_W-1:0] LAST = ROT_W'(STEPS - 1);

  logic             busy_q, done_q;
  logic [ROT_W-1:0] cnt_q;

  assign accept_o = start_i && !busy_q;
  assign busy_o   = busy_q;
  assign step_o   = cnt_q;
  assign last_o   = busy_q && (cnt_q == LAST);
  assign done_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == LAST) busy_q <= 1'b0;
        else               cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  a_r8_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  a_r8_done_after_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> $past(busy_q));
  a_r9_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_o) |=> busy_q);
endmodule

// File: rtl/rimm_best.sv
// Keeps the closest candidate across rotations; publishes on the last step.
module rimm_best #(
  parameter int unsigned W     = 32,
  parameter int unsigned IMM_W = 8,
  parameter int unsigned ROT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_en_i,
  input  logic             last_i,
  input  rimm_pkg::dir_e   dir_i,
  input  logic [W-1:0]     value_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             exact_i,
  input  logic [IMM_W-1:0] exact_imm_i,
  input  logic             cand_ok_i,
  input  logic [W-1:0]     cand_i,
  input  logic [IMM_W-1:0] cand_imm_i,
  output logic             valid_o,
  output logic             exact_o,
  output logic [W-1:0]     result_o,
  output logic [IMM_W-1:0] imm_o,
  output logic [ROT_W-1:0] rot_o
);
  logic             found_q, hit_q, found_d, hit_d;
  logic [W-1:0]     val_q, val_d;
  logic [IMM_W-1:0] imm_q, imm_d;
  logic [ROT_W-1:0] rot_q, rot_d;
  logic             better;

  always_comb begin
    found_d = found_q;
    hit_d   = hit_q;
    val_d   = val_q;
    imm_d   = imm_q;
    rot_d   = rot_q;
    better  = (dir_i == rimm_pkg::DIR_UP) ? (cand_i < val_q) : (cand_i > val_q);
    if (!hit_q) begin
      if (exact_i) begin
        found_d = 1'b1;
        hit_d   = 1'b1;
        val_d   = value_i;
        imm_d   = exact_imm_i;
        rot_d   = rot_i;
      end else if (cand_ok_i && (!found_q || better)) begin
        found_d = 1'b1;
        val_d   = cand_i;
        imm_d   = cand_imm_i;
        rot_d   = rot_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_q  <= 1'b0;
      hit_q    <= 1'b0;
      val_q    <= '0;
      imm_q    <= '0;
      rot_q    <= '0;
      valid_o  <= 1'b0;
      exact_o  <= 1'b0;
      result_o <= '0;
      imm_o    <= '0;
      rot_o    <= '0;
    end else if (clear_i) begin
      found_q <= 1'b0;
      hit_q   <= 1'b0;
      val_q   <= '0;
      imm_q   <= '0;
      rot_q   <= '0;
    end else if (step_en_i) begin
      found_q <= found_d;
      hit_q   <= hit_d;
      val_q   <= val_d;
      imm_q   <= imm_d;
      rot_q   <= rot_d;
      if (last_i) begin
        valid_o  <= found_d;
        exact_o  <= hit_d;
        result_o <= val_d;
        imm_o    <= imm_d;
        rot_o    <= rot_d;
      end
    end
  end

  // candidates never cross the requested side of the constant
  a_r3_cand_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && cand_ok_i && !exact_i && dir_i == rimm_pkg::DIR_DOWN) |-> cand_i < value_i);
  a_r4_cand_above: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_en_i && cand_ok_i && !exact_i && dir_i == rimm_pkg::DIR_UP) |-> cand_i > value_i);
endmodule

// File: rtl/rimm_finder.sv
module rimm_finder #(
  parameter int unsigned WORD_W = rimm_pkg::DEF_WORD_W,
  parameter int unsigned IMM_W  = rimm_pkg::DEF_IMM_W
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [WORD_W-1:0]           value_i,
  input  logic                        up_i,
  output logic                        done_o,
  output logic                        valid_o,
  output logic                        exact_o,
  output logic [WORD_W-1:0]           result_o,
  output logic [IMM_W-1:0]            imm_o,
  output logic [$clog2(WORD_W/2)-1:0] rot_o
);
  localparam int unsigned STEPS = WORD_W / 2;
  localparam int unsigned ROT_W = $clog2(STEPS);

  logic              accept, busy, last;
  logic [ROT_W-1:0]  step;
  logic [WORD_W-1:0] value_q;
  rimm_pkg::dir_e    dir_q;
  logic              s_exact, s_cand_ok;
  logic [IMM_W-1:0]  s_exact_imm, s_cand_imm;
  logic [WORD_W-1:0] s_cand;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      value_q <= '0;
      dir_q   <= rimm_pkg::DIR_DOWN;
    end else if (accept) begin
      value_q <= value_i;
      dir_q   <= rimm_pkg::dir_e'(up_i);
    end
  end

  rimm_ctrl #(.STEPS(STEPS), .ROT_W(ROT_W)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .accept_o(accept), .busy_o(busy), .last_o(last), .step_o(step), .done_o
  );

  rimm_step #(.W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_step (
    .value_i(value_q), .rot_i(step), .dir_i(dir_q),
    .exact_o(s_exact), .exact_imm_o(s_exact_imm),
    .cand_ok_o(s_cand_ok), .cand_o(s_cand), .cand_imm_o(s_cand_imm)
  );

  rimm_best #(.W(WORD_W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_best (
    .clk_i, .rst_ni,
    .clear_i(accept), .step_en_i(busy), .last_i(last), .dir_i(dir_q),
    .value_i(value_q), .rot_i(step),
    .exact_i(s_exact), .exact_imm_i(s_exact_imm),
    .cand_ok_i(s_cand_ok), .cand_i(s_cand), .cand_imm_i(s_cand_imm),
    .valid_o, .exact_o, .result_o, .imm_o, .rot_o
  );

  // rebuild result from the published fields
  logic [2*WORD_W-1:0] rb_dbl;
  logic [WORD_W-1:0]   rebuilt;
  always_comb begin
    rb_dbl  = {{(WORD_W-IMM_W){1'b0}}, imm_o, {(WORD_W-IMM_W){1'b0}}, imm_o};
    rebuilt = rb_dbl[2*int'(rot_o) +: WORD_W];
  end

  a_r2_fields_rebuild: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o) |-> rebuilt == result_o);
  a_r1_exact_matches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && exact_o) |-> result_o == value_q);
  a_r7_invalid_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !valid_o) |-> (result_o == '0 && dir_q == rimm_pkg::DIR_UP));
  a_r3_side_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o && dir_q == rimm_pkg::DIR_DOWN) |-> result_o <= value_q);
  a_r4_side_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && valid_o && dir_q == rimm_pkg::DIR_UP) |-> result_o >= value_q);
  a_r9_value_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !last) |=> $stable(value_q));
  a_r10_hold_results: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!last) |=> $stable(result_o));
endmodule

// File: tb/sim_rimm_finder.sv
module sim_rimm_finder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] value = '0;
  logic        up = 1'b0;
  logic        done, valid, exact;
  logic [31:0] result;
  logic [7:0]  imm;
  logic [3:0]  rot;
  int          errors = 0;
  int          checks = 0;
  logic        finished = 1'b0;

  always #5 clk = ~clk;

  rimm_finder u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .value_i(value), .up_i(up),
    .done_o(done), .valid_o(valid), .exact_o(exact), .result_o(result),
    .imm_o(imm), .rot_o(rot)
  );

  function automatic logic [31:0] ror_k(input logic [7:0] k, input int r);
    logic [63:0] d;
    d = {24'd0, k, 24'd0, k};
    return d[2*r +: 32];
  endfunction

  // exhaustive reference over all rotated 8-bit values
  task automatic model(input logic [31:0] v, input logic u, output logic ok,
                       output logic ex, output logic [31:0] val,
                       output logic [7:0] ik, output logic [3:0] ir);
    ok = 1'b0; val = '0; ik = '0; ir = '0;
    for (int r = 0; r < 16; r++) begin
      for (int k = 0; k < 256; k++) begin
        logic [31:0] c;
        logic side, better;
        c = ror_k(8'(k), r);
        side   = u ? (c >= v) : (c <= v);
        better = u ? (c < val) : (c > val);
        if (side && (!ok || better)) begin
          ok = 1'b1; val = c; ik = 8'(k); ir = 4'(r);
        end
      end
    end
    ex = ok && (val == v);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] v, input logic u, input logic glitch, input string tag);
    logic ok, ex;
    logic [31:0] ev;
    logic [7:0] ei;
    logic [3:0] er;
    model(v, u, ok, ex, ev, ei, er);
    @(negedge clk); start = 1'b1; value = v; up = u;
    @(negedge clk); start = 1'b0;
    for (int k = 1; k <= 16; k++) begin
      @(negedge clk);
      if (glitch && k == 4) begin start = 1'b1; value = ~v; up = ~u; end
      else start = 1'b0;
      if (k < 16) chk("R8 done early", 32'(done), 32'd0);
    end
    chk("R8 done at 16", 32'(done), 32'd1);
    chk({"R1/R6 exact ", tag}, 32'(exact), 32'(ex));
    chk({"R7 valid ", tag}, 32'(valid), 32'(ok));
    chk({u ? "R4 result " : "R3 result ", tag}, result, ev);
    chk({"R2 imm ", tag}, 32'(imm), 32'(ei));
    chk({"R2 rot ", tag}, 32'(rot), 32'(er));
    if (glitch) chk("R9 glitch ignored", result, ev);
    @(negedge clk);
    chk("R8 done one cycle", 32'(done), 32'd0);
    chk("R10 result held", result, ev);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] s;
    s = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R10 reset done", 32'(done), 32'd0);
    chk("R10 reset valid", 32'(valid), 32'd0);
    chk("R10 reset exact", 32'(exact), 32'd0);
    chk("R10 reset result", result, 32'd0);
    chk("R10 reset fields", {20'd0, imm, rot}, 32'd0);
    rst_n = 1'b1;

    run(32'h0000_5000, 1'b0, 1'b0, "R1 0x5000");
    chk("R1 0x5000 exact", 32'(exact), 32'd1);
    run(32'h0000_5001, 1'b0, 1'b0, "R3 0x5001");
    chk("R3 0x5001 down", result, 32'h0000_5000);
    chk("R1 0x5001 not exact", 32'(exact), 32'd0);
    run(32'h0000_5001, 1'b1, 1'b0, "R4 0x5001");
    run(32'h8000_0001, 1'b0, 1'b0, "R5 wrap");
    chk("R5 wrap imm", 32'(imm), 32'h06);
    chk("R5 wrap rot", 32'(rot), 32'd1);
    run(32'h8000_0003, 1'b1, 1'b0, "R5 wrap up");
    run(32'hC000_007F, 1'b0, 1'b0, "R5 wrap down");
    run(32'h0, 1'b0, 1'b0, "R6 zero down");
    run(32'h0, 1'b1, 1'b0, "R6 zero up");
    chk("R6 zero rot", 32'(rot), 32'd0);
    run(32'hFF00_0001, 1'b1, 1'b0, "R7 none");
    chk("R7 no candidate", 32'(valid), 32'd0);
    run(32'hFFFF_FFFF, 1'b1, 1'b0, "R7 all ones up");
    run(32'hFFFF_FFFF, 1'b0, 1'b0, "R3 all ones down");
    run(32'hFF00_0000, 1'b1, 1'b0, "R4 max encodable");
    run(32'h0000_01FF, 1'b1, 1'b0, "R4 carry");
    run(32'h1234_5678, 1'b0, 1'b1, "R9 glitch");

    for (int i = 0; i < 240; i++) begin
      logic [31:0] v;
      case (i % 3)
        0: v = $urandom;
        1: v = ror_k(8'($urandom), int'($urandom % 16));
        default: v = ror_k(8'($urandom), int'($urandom % 16)) + 32'($urandom % 5) - 32'd2;
      endcase
      run(v, 1'($urandom), (i % 40) == 7, "random");
    end

    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule